// File: doc/BRIEF.md
# Parallel path-list convolutional decoder

This block decodes a hard-decision stream of a rate-1/2, memory-2 convolutional code whose frames are closed with two zero tail bits. Instead of accumulating distance metrics, it keeps a bounded list of candidate paths. Each path holds an encoder state and the bits decoded so far. Each received 2-bit codeword extends every path by exact lookup. A path that matches one of its two outgoing branches follows that branch. A path whose codeword is impossible from its state splits into both branches that are legal from that state.

A frame opens with a start pulse. After that, one codeword is accepted per clock whenever `in_valid` and `in_ready` are both high, and `in_last` marks the final codeword of the frame. When the frame closes, the block reports the message of the first path in the list that has returned to the all-zero state. If no path has returned there, it raises a fail flag. The result stays on the outputs until the next start pulse. The list has a fixed capacity. Branches that do not fit are discarded, and a sticky overflow flag records that this happened.

Top module: `pathlist_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `fail`, `overflow` and `in_ready` are 0 and `msg_out` is 0, until a start pulse arrives.
- R2: A start pulse always takes priority and restarts the decoder. On the next cycle the list holds one path in state 00 with an empty message, `msg_len` is 0, `done` and `overflow` are 0, and `in_ready` is 1. A codeword offered in the start cycle is not consumed, because `in_ready` is 0 while `start` is high.
- R3: A state is encoded as {u(t-1), u(t-2)}. `in_code[1]` carries v1 = u^u(t-1)^u(t-2) and `in_code[0]` carries v2 = u^u(t-2). The next state is {u, u(t-1)}. Each accepted codeword increments `msg_len` by one. A path whose state has a branch producing that codeword takes that branch in its own slot and appends the branch's input bit u.
- R4: A path with no branch producing the codeword forks. Its u=0 successor stays in its own slot. Its u=1 successor is appended at the first slot past the occupied ones. Forking paths are served in ascending slot order, so the list stays packed from slot 0.
- R5: All extensions in a cycle are computed from the list as it stood before that cycle. A successor appended in a cycle is not extended again until the next accepted codeword.
- R6: The list holds at most SLOTS paths. An appended successor that finds no free slot is discarded, and `overflow` goes to 1 and stays there until the next start.
- R7: The frame ends on an accepted codeword that has `in_last` set, or on the MAXLEN-th accepted codeword. On the next cycle `done` is 1 and `in_ready` is 0. `done`, `msg_len` and the result then hold until the next start.
- R8: When `done` is 1, `msg_out` is the message of the lowest-index path whose state is 00. Bit k of `msg_out` is the k-th decoded bit, counted from 0, and the two tail bits are included. Bits at and above `msg_len` are 0.
- R9: When `done` is 1 and no path is in state 00, `fail` is 1 and `msg_out` is 0. `fail` is 0 whenever `done` is 0.
- R10: The received frame 11,11,00,01,01,11 gives `msg_out` = 0x000D (decoded bits 1,0,1,1,0,0), `msg_len` = 6, and `fail` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new frame |
| in_valid | input | 1 | A received codeword is offered |
| in_ready | output | 1 | The decoder accepts a codeword this cycle |
| in_code | input | 2 | Received codeword, bit 1 is v1 |
| in_last | input | 1 | The offered codeword closes the frame |
| done | output | 1 | The frame has been decoded and the result is valid |
| fail | output | 1 | No path ended in the all-zero state |
| overflow | output | 1 | At least one successor was discarded in this frame |
| msg_out | output | MAXLEN | Decoded message, first bit in bit 0 |
| msg_len | output | clog2(MAXLEN+1) | Number of codewords consumed in the frame |

## Verification
The hardest conditions to reach from the ports are a full path list and several paths competing for the result. In both, slot order and discarded successors decide the outcome. Offering codeword 10 repeatedly from the start state makes the list grow in a Fibonacci-like way, and it passes sixteen paths on the sixth codeword. Randomly corrupted frames of random length, with idle gaps, create many forks and ties on state 00. The frame that fills MAXLEN without `in_last` and the start pulse arriving together with a valid codeword cover the two edges of the frame.

// File: rtl/pathlist_decoder.sv
module pathlist_decoder #(
  parameter int SLOTS  = 16,
  parameter int MAXLEN = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [1:0]                   in_code,
  input  logic                         in_last,
  output logic                         done,
  output logic                         fail,
  output logic                         overflow,
  output logic [MAXLEN-1:0]            msg_out,
  output logic [$clog2(MAXLEN+1)-1:0]  msg_len
);
  localparam int SW = $clog2(SLOTS);
  localparam int LW = $clog2(MAXLEN+1);
  localparam logic [LW-1:0] LAST_IDX = LW'(MAXLEN-1);

  logic              busy;
  logic [SW:0]       cnt;
  logic [LW-1:0]     len;
  logic [1:0]        st    [SLOTS];
  logic [MAXLEN-1:0] msg   [SLOTS];
  logic [1:0]        st_n  [SLOTS];
  logic [MAXLEN-1:0] msg_n [SLOTS];
  logic [SW:0]       cnt_n;
  logic              ovf_n;
  logic              take, fin, found;
  logic [SW-1:0]     sel;

  assign in_ready = busy & ~start;
  assign take     = in_ready & in_valid;
  assign fin      = take & (in_last | (len == LAST_IDX));

  always_comb begin : extend
    logic [1:0]        s, c0;
    logic [SW:0]       pos;
    logic [MAXLEN-1:0] one_at;
    pos    = cnt;
    ovf_n  = overflow;
    one_at = {{(MAXLEN-1){1'b0}}, 1'b1} << len;
    s      = 2'b00;
    c0     = 2'b00;
    for (int i = 0; i < SLOTS; i++) begin
      st_n[i]  = st[i];
      msg_n[i] = msg[i];
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (i < int'(cnt)) begin
        s  = st[i];
        c0 = {s[1] ^ s[0], s[0]};
        if (in_code == c0) begin
          st_n[i] = {1'b0, s[1]};
        end else if (in_code == ~c0) begin
          st_n[i]  = {1'b1, s[1]};
          msg_n[i] = msg[i] | one_at;
        end else begin
          st_n[i] = {1'b0, s[1]};
          if (pos[SW]) begin
            ovf_n = 1'b1;
          end else begin
            st_n[pos[SW-1:0]]  = {1'b1, s[1]};
            msg_n[pos[SW-1:0]] = msg[i] | one_at;
            pos = pos + (SW+1)'(1);
          end
        end
      end
    end
    cnt_n = pos;
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (i < int'(cnt) && st[i] == 2'b00) begin
        found = 1'b1;
        sel   = SW'(i);
      end
    end
  end

  assign msg_out = (done & found) ? msg[sel] : '0;
  assign fail    = done & ~found;
  assign msg_len = len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
      cnt      <= '0;
      len      <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        st[i]  <= 2'b00;
        msg[i] <= '0;
      end
    end else if (start) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      overflow <= 1'b0;
      cnt      <= (SW+1)'(1);
      len      <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        st[i]  <= 2'b00;
        msg[i] <= '0;
      end
    end else if (take) begin
      st       <= st_n;
      msg      <= msg_n;
      cnt      <= cnt_n;
      overflow <= ovf_n;
      len      <= len + LW'(1);
      if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_fresh_list_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == (SW+1)'(1) && st[0] == 2'b00 && len == '0 && !done && !overflow));

  assert_len_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (len == $past(len) + LW'(1)));

  assert_list_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt >= $past(cnt)) && ({1'b0, cnt} <= {$past(cnt), 1'b0}));

  assert_paths_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[SW] |-> (cnt[SW-1:0] == '0));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow);

  assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done && !busy));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(len) && $stable(msg_out)));
endmodule

// File: tb/pathlist_decoder_bench.sv
module pathlist_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS  = 16;
  localparam int MAXLEN = 16;
  localparam int LW     = $clog2(MAXLEN+1);
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [1:0] in_code = 2'b00;
  logic in_ready, done, fail, overflow;
  logic [MAXLEN-1:0] msg_out;
  logic [LW-1:0] msg_len;

  pathlist_decoder #(.SLOTS(SLOTS), .MAXLEN(MAXLEN)) u_pathlist_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .in_last(in_last),
    .done(done), .fail(fail), .overflow(overflow),
    .msg_out(msg_out), .msg_len(msg_len));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit ended = 0;

  int m_st[$];
  logic [MAXLEN-1:0] m_msg[$];
  int m_len = 0;
  bit m_busy = 0, m_done = 0, m_ovf = 0;

  function automatic logic [1:0] enc(int s, int u);
    logic v1, v2;
    v1 = 1'(u) ^ 1'((s >> 1) & 1) ^ 1'(s & 1);
    v2 = 1'(u) ^ 1'(s & 1);
    return {v1, v2};
  endfunction

  function automatic int nxt(int s, int u);
    return (u << 1) | ((s >> 1) & 1);
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int idx = -1;
    logic [MAXLEN-1:0] em = '0;
    for (int i = 0; i < m_st.size(); i++)
      if (idx < 0 && m_st[i] == 0) idx = i;
    if (m_done && idx >= 0) em = m_msg[idx];
    check("R7 done", 64'(done), 64'(m_done));
    check("R9 fail", 64'(fail), 64'(m_done && idx < 0));
    check("R6 overflow", 64'(overflow), 64'(m_ovf));
    check("R3 R4 R5 R8 msg_out lowest slot in state 00", 64'(msg_out), 64'(em));
    check("R3 msg_len", 64'(msg_len), 64'(m_len));
  endtask

  task automatic model_step(bit s_, bit v_, logic [1:0] code, bit last_);
    int nst[$];
    logic [MAXLEN-1:0] nmsg[$];
    if (s_) begin
      m_st = {0}; m_msg = {'0}; m_len = 0;
      m_busy = 1; m_done = 0; m_ovf = 0;
    end else if (m_busy && v_) begin
      nst = m_st; nmsg = m_msg;
      for (int i = 0; i < m_st.size(); i++) begin
        bit got = 0;
        for (int u = 0; u < 2; u++)
          if (enc(m_st[i], u) == code) begin
            nst[i]  = nxt(m_st[i], u);
            nmsg[i] = m_msg[i] | (MAXLEN'(u) << m_len);
            got = 1;
          end
        if (!got) begin
          nst[i] = nxt(m_st[i], 0);
          if (nst.size() < SLOTS) begin
            nst.push_back(nxt(m_st[i], 1));
            nmsg.push_back(m_msg[i] | (MAXLEN'(1) << m_len));
          end else m_ovf = 1;
        end
      end
      m_st = nst; m_msg = nmsg; m_len++;
      if (last_ || m_len == MAXLEN) begin m_busy = 0; m_done = 1; end
    end
  endtask

  task automatic step(bit s_, bit v_, logic [1:0] code, bit last_);
    @(negedge clk);
    compare();
    start = s_; in_valid = v_; in_code = code; in_last = last_;
    #1;
    check("R2 in_ready", 64'(in_ready), 64'(m_busy && !s_));
    model_step(s_, v_, code, last_);
  endtask

  task automatic frame(logic [1:0] cw[$], bit use_last, bit gaps);
    step(1, 0, 2'b00, 0);
    for (int i = 0; i < cw.size(); i++) begin
      if (gaps && ($urandom % 3 == 0)) step(0, 0, 2'b11, 1);
      step(0, 1, cw[i], use_last && (i == cw.size()-1));
    end
    step(0, 0, 2'b00, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [1:0] cw[$];
    repeat (3) @(negedge clk);
    check("R1 done in reset", 64'(done), 0);
    check("R1 fail in reset", 64'(fail), 0);
    check("R1 overflow in reset", 64'(overflow), 0);
    check("R1 in_ready in reset", 64'(in_ready), 0);
    check("R1 msg_out in reset", 64'(msg_out), 0);
    rst_n = 1'b1;
    step(0, 1, 2'b11, 1);
    step(0, 0, 2'b00, 0);
    check("R1 idle after reset ignores codewords", 64'(msg_len), 0);

    cw = {2'b11, 2'b11, 2'b00, 2'b01, 2'b01, 2'b11};
    frame(cw, 1, 0);
    check("R10 example msg_out", 64'(msg_out), 64'h000D);
    check("R10 example msg_len", 64'(msg_len), 6);
    check("R10 example fail", 64'(fail), 0);

    cw = {2'b11, 2'b11, 2'b11};
    frame(cw, 1, 0);
    check("R5 R8 fork result msg_out", 64'(msg_out), 64'h0001);

    begin
      int s = 0;
      int bits[$] = {1, 1, 0, 1, 0, 0, 0};
      logic [MAXLEN-1:0] em = '0;
      cw = {};
      foreach (bits[k]) begin
        cw.push_back(enc(s, bits[k]));
        s = nxt(s, bits[k]);
        em |= MAXLEN'(bits[k]) << k;
      end
      frame(cw, 1, 1);
      check("R3 clean frame msg_out", 64'(msg_out), 64'(em));
      check("R3 clean frame no overflow", 64'(overflow), 0);
    end

    cw = {2'b11};
    frame(cw, 1, 0);
    check("R9 no zero path fail", 64'(fail), 1);
    check("R9 no zero path msg_out", 64'(msg_out), 0);

    cw = {};
    repeat (8) cw.push_back(2'b10);
    frame(cw, 1, 0);
    check("R6 overflow raised", 64'(overflow), 1);
    check("R4 list capped result done", 64'(done), 1);

    cw = {};
    repeat (MAXLEN) cw.push_back(2'b00);
    frame(cw, 0, 0);
    check("R7 forced end done", 64'(done), 1);
    check("R7 forced end msg_len", 64'(msg_len), MAXLEN);
    check("R7 forced end in_ready", 64'(in_ready), 0);

    step(1, 0, 2'b00, 0);
    step(0, 1, 2'b11, 0);
    step(0, 1, 2'b10, 0);
    step(1, 1, 2'b11, 0);
    step(0, 0, 2'b00, 0);
    check("R2 restart with codeword in start cycle", 64'(msg_len), 0);
    check("R2 restart clears done", 64'(done), 0);

    for (int f = 0; f < 60; f++) begin
      int s = 0;
      int n = 1 + ($urandom % (MAXLEN-2));
      cw = {};
      for (int k = 0; k < n; k++) begin
        int u = (k >= n-2) ? 0 : int'($urandom % 2);
        logic [1:0] c = enc(s, u);
        if ($urandom % 6 == 0) c ^= 2'(1 << ($urandom % 2));
        cw.push_back(c);
        s = nxt(s, u);
      end
      frame(cw, 1, 1);
    end

    step(0, 0, 2'b00, 0);
    finish_run();
  end
endmodule